// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a single-data-rate SDRAM interface. It samples the control strobes, the address bus and the bank-select bits on each rising clock edge. From those it decodes the command and pulls out the row or column address. It also keeps, for each of four banks, whether the bank is open and which row is open in it. Downstream array and data-path logic use its registered strobes, target bank and address, and the auto-precharge flag. The per-bank state lets them tell a legal access from a protocol violation.

Address bit 10 has two meanings. On a read or write it asks for the addressed bank to close by itself after the burst. A per-bank counter of `BURST_LEN` cycles carries that out. On a precharge it widens the command to every bank. The column field depends on the device organization. The widest organization takes one non-contiguous address bit above bit 10. When clock-enable is low, the block treats the clock as stopped and raises a low-power indicator.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Commands are decoded from {ras_n, cas_n, we_n} sampled while cs_n=0 and cke=1. The codes are 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode-register set, 110 burst terminate, and 111 no-op. The matching strobe is high for exactly the cycle after the sampling edge, and at most one strobe is high at a time.
- R2: A command sampled with cs_n=1 produces no strobe and changes no bank state. A pending auto-precharge still counts down and closes its bank.
- R3: Activate to a closed bank opens that bank. It stores addr[12:0] as the bank's open row, seen on `open_rows[13*b +: 13]`. On every accepted command, `cmd_bank` and `cmd_row` take the sampled ba and addr. They hold their value otherwise.
- R4: On every accepted command, `cmd_col` is taken from the address. For ORG=0 it is {addr[11], addr[9:0]} (11 bits). For ORG=1 it is addr[9:0], and for ORG=2 it is addr[8:0].
- R5: A read or write to an open bank with addr[10]=1 drives `cmd_ap` high with the strobe. The addressed bank then closes on the BURST_LEN-th clock edge after the accepting edge. A read or write with addr[10]=0 leaves the bank open and `cmd_ap` low.
- R6: Precharge with addr[10]=0 closes only the bank named by ba and cancels that bank's pending auto-precharge.
- R7: Precharge with addr[10]=1 closes all four banks, whatever the value of ba.
- R8: `proto_err` pulses with the strobe in three cases: a read or write to a closed bank, an activate to an open bank, and an auto-refresh while any bank is open. The rejected command changes no bank state.
- R9: `low_power` is high in the cycle after an edge that samples cke=0. On such an edge no command is accepted and the auto-precharge counters hold their value.
- R10: After reset, all strobes, `proto_err`, `low_power`, `bank_open`, the stored rows and the captured address fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low stops command acceptance |
| cs_n | input | 1 | Active-low chip select |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| addr | input | 13 | Address bus |
| ba | input | 2 | Bank select |
| cmd_act | output | 1 | Activate decoded |
| cmd_rd | output | 1 | Read decoded |
| cmd_wr | output | 1 | Write decoded |
| cmd_pre | output | 1 | Precharge decoded |
| cmd_ref | output | 1 | Auto-refresh decoded |
| cmd_mrs | output | 1 | Mode-register set decoded |
| cmd_bst | output | 1 | Burst terminate decoded |
| cmd_bank | output | 2 | Bank of the last accepted command |
| cmd_row | output | 13 | Row field of the last accepted command |
| cmd_col | output | COL_W | Column field of the last accepted command |
| cmd_ap | output | 1 | Auto-precharge requested by this read or write |
| bank_open | output | 4 | Open flag per bank |
| open_rows | output | 52 | Open row per bank, bank b at bits 13*b+12 down to 13*b |
| proto_err | output | 1 | Protocol violation detected |
| low_power | output | 1 | Clock-enable was sampled low |

## Verification
The bench aims at the double meaning of address bit 10. If the precharge decode ignored it, a precharge-all with a nonzero ba would leave the other banks open. If the read/write decode ignored it, the bank would never close or `cmd_ap` would stay low. The auto-precharge close is checked at the exact edge while cs_n is high. A counter gated by chip select would close the bank late, and an off-by-one would close it a cycle early or late. The bench sends a column with bit 11 set, which catches a contiguous column slice. It also repeats an activate to an open bank and issues a refresh while a bank is open. Both must flag an error and leave the stored row alone. Commands with cs_n high and with cke low must produce no strobe.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ORG       = 0,
  parameter int BURST_LEN = 4,
  parameter int ROW_W     = 13,
  parameter int BA_W      = 2,
  localparam int NBANK    = 1 << BA_W,
  localparam int COL_W    = (ORG == 0) ? 11 : (ORG == 1) ? 10 : 9,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [ROW_W-1:0]       addr,
  input  logic [BA_W-1:0]        ba,
  output logic                   cmd_act,
  output logic                   cmd_rd,
  output logic                   cmd_wr,
  output logic                   cmd_pre,
  output logic                   cmd_ref,
  output logic                   cmd_mrs,
  output logic                   cmd_bst,
  output logic [BA_W-1:0]        cmd_bank,
  output logic [ROW_W-1:0]       cmd_row,
  output logic [COL_W-1:0]       cmd_col,
  output logic                   cmd_ap,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_rows,
  output logic                   proto_err,
  output logic                   low_power
);

  logic             accept;
  logic [2:0]       rcw;
  logic             is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, is_bst;
  logic             tgt_open, any_open, err_d;
  logic [COL_W-1:0] col_in;

  logic [ROW_W-1:0] row_q [NBANK];
  logic [CNT_W-1:0] cnt_q [NBANK];

  assign accept   = cke & ~cs_n;
  assign rcw      = {ras_n, cas_n, we_n};
  assign is_act   = accept && rcw == 3'b011;
  assign is_rd    = accept && rcw == 3'b101;
  assign is_wr    = accept && rcw == 3'b100;
  assign is_pre   = accept && rcw == 3'b010;
  assign is_ref   = accept && rcw == 3'b001;
  assign is_mrs   = accept && rcw == 3'b000;
  assign is_bst   = accept && rcw == 3'b110;
  assign tgt_open = bank_open[ba];
  assign any_open = |bank_open;
  assign err_d    = (is_act & tgt_open) | ((is_rd | is_wr) & ~tgt_open) | (is_ref & any_open);

  generate
    if (ORG == 0) begin : g_col_split
      assign col_in = {addr[11], addr[9:0]};
    end else begin : g_col_flat
      assign col_in = addr[COL_W-1:0];
    end
    for (genvar g = 0; g < NBANK; g++) begin : g_rows
      assign open_rows[g*ROW_W +: ROW_W] = row_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst} <= '0;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      cmd_ap    <= 1'b0;
      proto_err <= 1'b0;
      low_power <= 1'b0;
    end else begin
      {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst} <=
        {is_act, is_rd, is_wr, is_pre, is_ref, is_mrs, is_bst};
      cmd_ap    <= (is_rd | is_wr) & tgt_open & addr[10];
      proto_err <= err_d;
      low_power <= ~cke;
      if (accept) begin
        cmd_bank <= ba;
        cmd_row  <= addr;
        cmd_col  <= col_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_open <= '0;
      for (int b = 0; b < NBANK; b++) begin
        row_q[b] <= '0;
        cnt_q[b] <= '0;
      end
    end else if (cke) begin
      for (int b = 0; b < NBANK; b++) begin
        if (cnt_q[b] != '0) begin
          cnt_q[b] <= cnt_q[b] - 1'b1;
          if (cnt_q[b] == CNT_W'(1)) bank_open[b] <= 1'b0;
        end
        if (is_act && ba == BA_W'(b) && !bank_open[b]) begin
          bank_open[b] <= 1'b1;
          row_q[b]     <= addr;
        end
        if (is_pre && (addr[10] || ba == BA_W'(b))) begin
          bank_open[b] <= 1'b0;
          cnt_q[b]     <= '0;
        end
        if ((is_rd || is_wr) && ba == BA_W'(b) && bank_open[b] && addr[10])
          cnt_q[b] <= CNT_W'(BURST_LEN);
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int BA_W  = 2,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [12:0]      addr,
  input logic [BA_W-1:0]  ba,
  input logic             cmd_act,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_pre,
  input logic             cmd_ref,
  input logic             cmd_mrs,
  input logic             cmd_bst,
  input logic             cmd_ap,
  input logic [NBANK-1:0] bank_open,
  input logic             low_power
);

  logic any_strobe;
  assign any_strobe = cmd_act | cmd_rd | cmd_wr | cmd_pre | cmd_ref | cmd_mrs | cmd_bst;

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst}));

  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !any_strobe);

  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b011) |=> bank_open[$past(ba)]);

  assert_ap_with_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ap |-> (cmd_rd || cmd_wr));

  assert_pre_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !cs_n && {ras_n, cas_n, we_n} == 3'b010 && addr[10]) |=> bank_open == '0);

  assert_cke_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> (low_power && !any_strobe));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BA_W(BA_W), .NBANK(NBANK)) chk_i (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
  .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs),
  .cmd_bst(cmd_bst), .cmd_ap(cmd_ap), .bank_open(bank_open), .low_power(low_power)
);

// File: tb/sdram_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_tb_top;
  localparam int BL = 4;
  localparam int VW = 7 + 2 + 13 + 11 + 1 + 4 + 1 + 1 + 52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [1:0]  ba = '0;
  logic cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst, cmd_ap;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [10:0] cmd_col;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;
  logic proto_err, low_power;

  always #2 clk = ~clk;

  sdram_cmd_tracker #(.ORG(0), .BURST_LEN(BL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs),
    .cmd_bst(cmd_bst), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_ap(cmd_ap), .bank_open(bank_open), .open_rows(open_rows),
    .proto_err(proto_err), .low_power(low_power)
  );

  int n_cmp = 0, n_bad = 0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];

  logic [3:0]  m_open = '0;
  logic [12:0] m_row [4] = '{default: '0};
  int          m_cnt [4] = '{default: 0};
  logic [1:0]  m_bank = '0;
  logic [12:0] m_rowo = '0;
  logic [10:0] m_col = '0;

  function automatic logic [VW-1:0] actual();
    return {cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs, cmd_bst, cmd_bank,
            cmd_row, cmd_col, cmd_ap, bank_open, proto_err, low_power, open_rows};
  endfunction

  task automatic drive(input logic c, input logic [2:0] rcw, input logic [12:0] a,
                       input logic [1:0] b, input logic ke, input string tag);
    logic acc, act, rd, wr, pre, rf, mrs, bst, ap, err;
    logic [3:0] nopen;
    logic [51:0] rows;
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = rcw; addr = a; ba = b; cke = ke;
    acc = ke & ~c;
    act = acc && rcw == 3'b011; rd = acc && rcw == 3'b101; wr = acc && rcw == 3'b100;
    pre = acc && rcw == 3'b010; rf = acc && rcw == 3'b001; mrs = acc && rcw == 3'b000;
    bst = acc && rcw == 3'b110;
    err = (act && m_open[b]) || ((rd || wr) && !m_open[b]) || (rf && m_open != 0);
    ap  = (rd || wr) && m_open[b] && a[10];
    if (acc) begin m_bank = b; m_rowo = a; m_col = {a[11], a[9:0]}; end
    nopen = m_open;
    if (ke) begin
      for (int k = 0; k < 4; k++) begin
        if (m_cnt[k] != 0) begin
          if (m_cnt[k] == 1) nopen[k] = 1'b0;
          m_cnt[k]--;
        end
        if (act && b == k && !m_open[k]) begin nopen[k] = 1'b1; m_row[k] = a; end
        if (pre && (a[10] || b == k)) begin nopen[k] = 1'b0; m_cnt[k] = 0; end
        if ((rd || wr) && b == k && m_open[k] && a[10]) m_cnt[k] = BL;
      end
    end
    m_open = nopen;
    for (int k = 0; k < 4; k++) rows[k*13 +: 13] = m_row[k];
    exp_q.push_back({act, rd, wr, pre, rf, mrs, bst, m_bank, m_rowo, m_col, ap,
                     m_open, err, ~ke, rows});
    tag_q.push_back(tag);
  endtask

  task automatic nop(input string tag, input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 3'b111, 13'h0, 2'd0, 1'b1, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (actual() !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, actual(), e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    n_cmp++;
    if (actual() !== '0) begin
      n_bad++;
      $display("FAIL R10 reset: actual %h expected 0", actual());
    end
    @(negedge clk);
    rst_n = 1'b1;
    nop("R10 idle after reset", 2);
    drive(1'b0, 3'b011, 13'h1ABC, 2'd0, 1'b1, "R3 activate bank0");
    drive(1'b0, 3'b011, 13'h0123, 2'd2, 1'b1, "R3 activate bank2");
    drive(1'b0, 3'b101, 13'h0955, 2'd0, 1'b1, "R4 read col bit11, R5 no ap");
    drive(1'b0, 3'b100, 13'h0407, 2'd2, 1'b1, "R5 write with ap");
    drive(1'b1, 3'b011, 13'h0333, 2'd1, 1'b1, "R2 deselected activate");
    drive(1'b1, 3'b010, 13'h0400, 2'd0, 1'b1, "R2 deselected precharge all");
    drive(1'b1, 3'b111, 13'h0000, 2'd0, 1'b1, "R5 count while deselected");
    drive(1'b1, 3'b111, 13'h0000, 2'd0, 1'b1, "R5 bank2 closes");
    nop("R5 bank2 stays closed", 1);
    drive(1'b0, 3'b101, 13'h0010, 2'd1, 1'b1, "R8 read closed bank");
    drive(1'b0, 3'b011, 13'h0FFF, 2'd0, 1'b1, "R8 activate open bank");
    drive(1'b0, 3'b001, 13'h0000, 2'd0, 1'b1, "R8 refresh with bank open");
    drive(1'b0, 3'b011, 13'h1555, 2'd3, 1'b1, "R3 activate bank3");
    drive(1'b0, 3'b011, 13'h0777, 2'd1, 0, "R9 activate with cke low");
    drive(1'b0, 3'b111, 13'h0000, 2'd0, 1'b1, "R9 wake");
    drive(1'b0, 3'b010, 13'h0000, 2'd0, 1'b1, "R6 precharge bank0 only");
    drive(1'b0, 3'b011, 13'h0ABC, 2'd1, 1'b1, "R3 activate bank1");
    drive(1'b0, 3'b101, 13'h0402, 2'd1, 1'b1, "R5 read with ap");
    drive(1'b0, 3'b111, 13'h0000, 2'd0, 0, "R9 ap count frozen");
    drive(1'b0, 3'b111, 13'h0000, 2'd0, 0, "R9 ap count frozen");
    nop("R5 ap close after freeze", 4);
    drive(1'b0, 3'b011, 13'h0042, 2'd1, 1'b1, "R3 reopen bank1");
    drive(1'b0, 3'b010, 13'h0400, 2'd1, 1'b1, "R7 precharge all ba=1");
    drive(1'b0, 3'b001, 13'h0000, 2'd0, 1'b1, "R1 refresh all closed");
    drive(1'b0, 3'b000, 13'h0033, 2'd0, 1'b1, "R1 mode register set");
    drive(1'b0, 3'b110, 13'h0000, 2'd0, 1'b1, "R1 burst terminate");
    drive(1'b0, 3'b011, 13'h0100, 2'd2, 1'b1, "R3 activate bank2");
    drive(1'b0, 3'b100, 13'h0400, 2'd2, 1'b1, "R5 write ap");
    drive(1'b0, 3'b010, 13'h0000, 2'd2, 1'b1, "R6 precharge cancels ap");
    nop("R6 idle", 5);
    repeat (3) @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 queue: actual %0d left expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule